// File: doc/BRIEF.md
# Wait-Hint Trap Router

This block decides the outcome of a wait hint executed by a processor core. Each request names the hint type (wait-for-interrupt or wait-for-event) and carries the core's context: its current privilege level (0 to 3), whether it is a microcontroller-profile core, whether it is a version-8 core, its security state, and whether the top privilege level runs in 32-bit mode. It also carries the trap-control bits that software has programmed at levels 1, 2 and 3, the encoded instruction length, and a work-pending signal.

One cycle after the request strobe, the block reports one of four outcomes. The hint can retire at once, it can trap to a computed privilege level, the core can halt until woken, or the core can yield. A trap result also carries an exception syndrome byte and the number of bytes by which the program counter must be wound back. The block also holds a halted flag, which drops when work arrives. Exception entry itself and the register files lie outside this block.

Top module: `wfx_router`

## Requirements
- R1: `res_valid` is high for exactly the one cycle after a cycle with `req_valid` high, and low otherwise. The outcome codes on `res_kind` are: 0 retire, 1 trap, 2 halt, 3 yield.
- R2: A wait-for-event request (`req_is_event`=1) always gives yield (3), whatever the trap bits and work-pending are. It never changes `halted`.
- R3: A wait-for-interrupt request with `work_pending` high retires (0), even when the trap bits call for a trap.
- R4: A microcontroller-profile core (`is_mcu`=1) never traps. With no work pending it halts (2).
- R5: At level 0 on a version-8 core, the target level is 3 when `sec_below_top` and `top_is_32` are both set, and 1 otherwise. The request traps to that target when the target's no-trap bit (`l1_no_trap` or `l3_no_trap`) is clear.
- R6: If no trap came from the level-0 check and the current level is below 2, a set `hyp_trap` traps to level 2. This check takes priority over the level-3 check.
- R7: If there is still no trap and the current level is below 3, a set `sec_trap` traps to level 3. At level 3 no trap is ever taken.
- R8: The no-trap bits are ignored on a core that is not version 8, and at levels above 0.
- R9: On a trap, `pc_rewind` is 2 when `insn_short`=1 and 4 otherwise. `syndrome` is laid out as bit 7 = condition-valid (1), bits 6:3 = condition code 0xE, bit 2 = short-instruction flag, bits 1:0 = 0.
- R10: For any result that is not a trap, `trap_level`, `syndrome` and `pc_rewind` are 0.
- R11: `halted` rises in the same cycle as a halt result is reported. It stays high until the first clock edge at which `work_pending` is high, and is low after that edge.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_is_event | input | 1 | 1 = wait-for-event, 0 = wait-for-interrupt |
| cur_level | input | 2 | Current privilege level |
| is_mcu | input | 1 | Microcontroller-profile core |
| is_v8 | input | 1 | Version-8 core |
| sec_below_top | input | 1 | Secure state below the top level |
| top_is_32 | input | 1 | Top level runs in 32-bit mode |
| l1_no_trap | input | 1 | Level-1 control: do not trap wait-for-interrupt |
| l3_no_trap | input | 1 | Level-3 control: do not trap wait-for-interrupt |
| hyp_trap | input | 1 | Hypervisor control: trap wait-for-interrupt |
| sec_trap | input | 1 | Secure-monitor control: trap wait-for-interrupt |
| insn_short | input | 1 | Instruction is 16 bits long |
| work_pending | input | 1 | Interrupt or other work is pending |
| res_valid | output | 1 | Result valid |
| res_kind | output | 2 | Outcome code |
| trap_level | output | 2 | Target level of a trap |
| syndrome | output | 8 | Trap syndrome byte |
| pc_rewind | output | 3 | PC rewind in bytes |
| halted | output | 1 | Core is halted |

## Verification
A wrong priority between the three trap stages, or a wrong secure redirect, shows up as a wrong `trap_level` in the single result cycle that follows the strobe. Every result is fully visible one cycle after its request, so any decision fault appears within one clock. A stuck or leaky halted flag only shows over several cycles: the flag has to be watched while work stays idle, while a wait-for-event request goes by, and at the first edge where work-pending is high.

// File: rtl/wfx_pkg.sv
package wfx_pkg;
  localparam int LVL_W  = 2;
  localparam int SYN_W  = 8;
  localparam int COND_W = 4;
  localparam int REW_W  = 3;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

  typedef enum logic [1:0] {
    RES_RETIRE = 2'd0,
    RES_TRAP   = 2'd1,
    RES_HALT   = 2'd2,
    RES_YIELD  = 2'd3
  } res_kind_e;
endpackage

// File: rtl/wfx_trap_eval.sv
module wfx_trap_eval
  import wfx_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic [LW-1:0] cur_level,
  input  logic          is_mcu,
  input  logic          is_v8,
  input  logic          sec_below_top,
  input  logic          top_is_32,
  input  logic          l1_no_trap,
  input  logic          l3_no_trap,
  input  logic          hyp_trap,
  input  logic          sec_trap,
  output logic          take_trap,
  output logic [LW-1:0] target
);
  localparam logic [LW-1:0] LV0 = LW'(0);
  localparam logic [LW-1:0] LV1 = LW'(1);
  localparam logic [LW-1:0] LV2 = LW'(2);
  localparam logic [LW-1:0] LV3 = LW'(3);

  logic [LW-1:0] usr_tgt;
  logic          usr_hit;
  logic          hyp_hit;
  logic          sec_hit;

  always_comb begin
    // user-level check: the target level owns the no-trap bit
    usr_tgt = (sec_below_top && top_is_32) ? LV3 : LV1;
    usr_hit = (cur_level == LV0) && is_v8 &&
              !((usr_tgt == LV3) ? l3_no_trap : l1_no_trap);
    hyp_hit = (cur_level < LV2) && hyp_trap;
    sec_hit = (cur_level < LV3) && sec_trap;
    take_trap = 1'b0;
    target    = LV0;
    if (!is_mcu) begin
      if (usr_hit) begin
        take_trap = 1'b1;
        target    = usr_tgt;
      end else if (hyp_hit) begin
        take_trap = 1'b1;
        target    = LV2;
      end else if (sec_hit) begin
        take_trap = 1'b1;
        target    = LV3;
      end
    end
  end
endmodule

// File: rtl/wfx_syndrome_gen.sv
module wfx_syndrome_gen
  import wfx_pkg::*;
#(
  parameter int SW = SYN_W,
  parameter int RW = REW_W
) (
  input  logic          insn_short,
  output logic [SW-1:0] syn,
  output logic [RW-1:0] rewind
);
  localparam int PAD_W = SW - 2 - COND_W;
  always_comb begin
    syn    = {1'b1, COND_ALWAYS, insn_short, {PAD_W{1'b0}}};
    rewind = insn_short ? RW'(2) : RW'(4);
  end
endmodule

// File: rtl/wfx_halt_ctl.sv
module wfx_halt_ctl (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic wake,
  output logic halted
);
  always_ff @(posedge clk) begin
    if (rst)        halted <= 1'b0;
    else if (wake)  halted <= 1'b0;
    else if (enter) halted <= 1'b1;
  end

  a_r11_wake_clears: assert property (@(posedge clk) disable iff (rst)
    (halted && wake) |=> !halted);
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (halted && !wake) |=> halted);
endmodule

// File: rtl/wfx_router.sv
module wfx_router
  import wfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_is_event,
  input  logic [1:0] cur_level,
  input  logic       is_mcu,
  input  logic       is_v8,
  input  logic       sec_below_top,
  input  logic       top_is_32,
  input  logic       l1_no_trap,
  input  logic       l3_no_trap,
  input  logic       hyp_trap,
  input  logic       sec_trap,
  input  logic       insn_short,
  input  logic       work_pending,
  output logic       res_valid,
  output logic [1:0] res_kind,
  output logic [1:0] trap_level,
  output logic [7:0] syndrome,
  output logic [2:0] pc_rewind,
  output logic       halted
);
  logic             take_trap;
  logic [LVL_W-1:0] tgt;
  logic [SYN_W-1:0] syn_c;
  logic [REW_W-1:0] rew_c;
  res_kind_e        kind_nx;
  logic             halt_enter;

  wfx_trap_eval #(.LW(LVL_W)) u_eval (
    .cur_level(cur_level), .is_mcu(is_mcu), .is_v8(is_v8),
    .sec_below_top(sec_below_top), .top_is_32(top_is_32),
    .l1_no_trap(l1_no_trap), .l3_no_trap(l3_no_trap),
    .hyp_trap(hyp_trap), .sec_trap(sec_trap),
    .take_trap(take_trap), .target(tgt)
  );

  wfx_syndrome_gen #(.SW(SYN_W), .RW(REW_W)) u_syn (
    .insn_short(insn_short), .syn(syn_c), .rewind(rew_c)
  );

  always_comb begin
    if (req_is_event)      kind_nx = RES_YIELD;
    else if (work_pending) kind_nx = RES_RETIRE;
    else if (take_trap)    kind_nx = RES_TRAP;
    else                   kind_nx = RES_HALT;
  end

  assign halt_enter = req_valid && (kind_nx == RES_HALT);

  wfx_halt_ctl u_halt (
    .clk(clk), .rst(rst), .enter(halt_enter),
    .wake(work_pending), .halted(halted)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      res_valid  <= 1'b0;
      res_kind   <= RES_RETIRE;
      trap_level <= '0;
      syndrome   <= '0;
      pc_rewind  <= '0;
    end else begin
      res_valid <= 1'b1;
      res_kind  <= kind_nx;
      if (kind_nx == RES_TRAP) begin
        trap_level <= tgt;
        syndrome   <= syn_c;
        pc_rewind  <= rew_c;
      end else begin
        trap_level <= '0;
        syndrome   <= '0;
        pc_rewind  <= '0;
      end
    end
  end

  a_r1_result_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  a_r2_event_yields: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_event) |=> (res_kind == RES_YIELD));
  a_r2_event_keeps_halt: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_event && !work_pending) |=> $stable(halted));
  a_r3_pending_retires: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_event && work_pending) |=> (res_kind == RES_RETIRE));
  a_r4_mcu_no_trap: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_mcu) |=> (res_kind != RES_TRAP));
  a_r7_top_no_trap: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_level == 2'd3) |=> (res_kind != RES_TRAP));
  a_r9_trap_fields: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_kind == RES_TRAP) |->
      ((pc_rewind == 3'd2) == syndrome[2]) && (pc_rewind == 3'd2 || pc_rewind == 3'd4)
      && syndrome[7] && (syndrome[6:3] == 4'hE) && (trap_level != 2'd0));
  a_r10_quiet_fields: assert property (@(posedge clk) disable iff (rst)
    (res_kind != RES_TRAP) |-> (trap_level == 2'd0 && syndrome == 8'd0 && pc_rewind == 3'd0));
  a_r11_halt_with_result: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_kind == RES_HALT) |-> halted);
endmodule

// File: tb/wfx_router_tb.sv
module wfx_router_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_is_event = 0, is_mcu = 0, is_v8 = 0;
  logic sec_below_top = 0, top_is_32 = 0, l1_no_trap = 0, l3_no_trap = 0;
  logic hyp_trap = 0, sec_trap = 0, insn_short = 0, work_pending = 0;
  logic [1:0] cur_level = 0;
  logic       res_valid, halted;
  logic [1:0] res_kind, trap_level;
  logic [7:0] syndrome;
  logic [2:0] pc_rewind;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wfx_router u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_event(req_is_event),
    .cur_level(cur_level), .is_mcu(is_mcu), .is_v8(is_v8),
    .sec_below_top(sec_below_top), .top_is_32(top_is_32),
    .l1_no_trap(l1_no_trap), .l3_no_trap(l3_no_trap),
    .hyp_trap(hyp_trap), .sec_trap(sec_trap), .insn_short(insn_short),
    .work_pending(work_pending), .res_valid(res_valid), .res_kind(res_kind),
    .trap_level(trap_level), .syndrome(syndrome), .pc_rewind(pc_rewind),
    .halted(halted)
  );

  // {ev, lvl[1:0], mcu, v8, sec, t32, l1n, l3n, hyp, scr, short, work, kind[1:0], tlvl[1:0]}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    17'b0_00_0_1_0_0_0_1_0_0_0_0_01_01, // R5 user trap to 1
    17'b0_00_0_1_0_0_1_1_0_0_0_0_10_00, // R5 no-trap set: halt
    17'b0_00_0_1_1_1_1_0_0_0_0_0_01_11, // R5 secure redirect to 3
    17'b0_00_0_1_1_0_0_1_0_0_0_0_01_01, // R5 secure, 64-bit top: level 1
    17'b0_00_0_1_0_0_1_1_1_0_1_0_01_10, // R6 hyp trap from level 0, short
    17'b0_01_0_1_0_0_0_0_1_1_0_0_01_10, // R6 hyp beats secure, R8 level 1
    17'b0_10_0_1_0_0_1_1_1_0_0_0_10_00, // R6 hyp ignored at level 2
    17'b0_10_0_1_0_0_1_1_0_1_0_0_01_11, // R7 secure trap from level 2
    17'b0_11_0_1_0_0_0_0_1_1_0_0_10_00, // R7 nothing traps at level 3
    17'b0_00_0_0_0_0_0_0_0_0_0_0_10_00, // R8 non-v8 ignores no-trap bits
    17'b0_00_1_1_0_0_0_0_1_1_0_0_10_00, // R4 mcu never traps
    17'b0_00_0_1_0_0_0_0_1_1_0_1_00_00, // R3 pending work retires
    17'b1_00_0_1_0_0_0_0_1_1_0_0_11_00, // R2 event yields
    17'b1_01_0_1_0_0_1_1_0_0_0_1_11_00, // R2 event with work yields
    17'b0_01_0_0_0_0_1_1_0_1_1_0_01_11  // R7 secure trap from level 1, short
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [12:0] f);
    {req_is_event, cur_level, is_mcu, is_v8, sec_below_top, top_is_32,
     l1_no_trap, l3_no_trap, hyp_trap, sec_trap, insn_short, work_pending} = f;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 valid", res_valid, 0);
    check("R12 kind", res_kind, 0);
    check("R12 syndrome", syndrome, 0);
    check("R12 halted", halted, 0);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      logic        sh;
      v  = VEC[i];
      sh = v[5];
      issue(v[16:4]);
      check("R1 valid", res_valid, 1);
      check("R1 kind", res_kind, v[3:2]);
      check("R5 level", trap_level, v[1:0]);
      if (v[3:2] == 2'd1) begin
        check("R9 syndrome", syndrome, {1'b1, 4'hE, sh, 2'b00});
        check("R9 rewind", pc_rewind, sh ? 2 : 4);
      end else begin
        check("R10 syndrome", syndrome, 0);
        check("R10 rewind", pc_rewind, 0);
      end
    end

    // R1 result lasts one cycle
    @(negedge clk);
    check("R1 drop", res_valid, 0);

    // R11 halt then wake
    work_pending = 1'b0;
    issue(13'b0_00_0_1_0_0_1_1_0_0_0_0);
    check("R11 halt kind", res_kind, 2);
    check("R11 halted rises", halted, 1);
    repeat (3) @(negedge clk);
    check("R11 halted holds", halted, 1);
    // R2 event leaves halted untouched
    issue(13'b1_00_0_1_0_0_0_0_1_1_0_0);
    check("R2 yield", res_kind, 3);
    check("R2 halted kept", halted, 1);
    work_pending = 1'b1;
    @(negedge clk);
    check("R11 woken", halted, 0);
    work_pending = 1'b0;
    @(negedge clk);
    check("R11 stays awake", halted, 0);

    // R12 reset clears halted
    issue(13'b0_11_0_0_0_0_0_0_0_0_0_0);
    check("R11 halted again", halted, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 halted reset", halted, 0);
    check("R12 valid reset", res_valid, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule